// File: doc/BRIEF.md
# Paged Program Counter with Bank Latch

This unit produces the instruction address for a 4-bit controller that executes 10-bit instruction words from a 4096-word program store. The address is split in two fields. The low six bits select a word inside a 64-word page. The upper bits select the page. The in-page field does not count in binary. It advances as a shift register whose inserted bit is the XNOR of its two top bits, so it walks a fixed 63-step sequence. The page field changes only through a deferred page-load instruction.

When the page-load instruction is presented with the status flag set, its low five bits are captured as the pending page. In the banked variant, a sixth page bit is also captured: the inverse of an external bank-control bit. The next instruction then runs at its normal sequential address, with interrupts blocked. The instruction after that starts in the new page. When the status flag is clear, the page-load instruction does nothing. A parameter selects a variant without banking, which confines the address to the lower half of the store. One instruction is consumed per cycle in which the fetch strobe is high.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset, `rom_addr` is 0 and `int_block` is 0.
- R2: In a cycle where `fetch` is 0, `rom_addr` and `int_block` keep their values, whatever the other inputs are.
- R3: On each fetch, `rom_addr[5:0]` becomes `{old[4:0], ~(old[5]^old[4])}`. Starting from 0, the value 6'h3F is never produced, and the sequence returns to its start after exactly 63 fetches.
- R4: A fetch while `int_block` is 0 leaves `rom_addr[11:6]` unchanged.
- R5: An opcode with `opcode[9:5] == 5'b11010` is a page-load. When it is fetched with `status` = 1, `int_block` is 1 for the following instruction, and it returns to 0 on the next fetch unless that fetch is also an acting page-load.
- R6: A page-load fetched with `status` = 0 behaves like any other instruction. It does not raise `int_block` and it does not alter the page.
- R7: After an acting page-load, the next fetch is still sequential. The fetch after that sets `rom_addr[10:6]` to the page-load's `opcode[4:0]`, while the low field still advances as in R3.
- R8: In the banked variant (BANKED=1), `rom_addr[11]` after the jump equals the inverse of `bank_bit` as sampled at the page-load fetch. With `bank_bit` = 1, execution stays in the lower half.
- R9: In the variant without banking (BANKED=0), `rom_addr[11]` is always 0.
- R10: When an acting page-load is fetched while `int_block` is 1, the earlier pending page is applied on that fetch. The new page is then held pending for the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch | input | 1 | One instruction consumed this cycle |
| opcode | input | 10 | Instruction word at the current address |
| status | input | 1 | Status flag that gates the page-load |
| bank_bit | input | 1 | Bank-control bit; 1 selects the lower half |
| rom_addr | output | ADDR_BITS | Current instruction address |
| int_block | output | 1 | Interrupt acceptance blocked for this instruction |

## Verification
The checker verifies on every cycle the following properties: idle cycles hold the state, the in-page field follows its shift rule and never reaches all ones, the page stays fixed while no jump is pending, `int_block` rises only after an acting page-load and falls correctly, and the variant without banking never leaves the lower half. Only the bench scenarios show the following: the exact page that lands two fetches after a page-load, the inversion of the bank bit, the 63-fetch period, and the handover between back-to-back page-loads. The bench covers every page field with both bank values and both status values, and applies all 1024 opcodes against a reference model.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
    localparam int OP_W      = 10;
    localparam int LOAD_FLD  = 5;
    localparam logic [OP_W-1:0] LOAD_MASK  = 10'h3E0;
    localparam logic [OP_W-1:0] LOAD_MATCH = 10'h340;
endpackage

// File: rtl/pc_page_step.sv
module pc_page_step #(
    parameter int PAGE_BITS = 6
) (
    input  logic [PAGE_BITS-1:0] cur,
    output logic [PAGE_BITS-1:0] nxt
);
    logic fb;
    always_comb begin
        fb  = ~(cur[PAGE_BITS-1] ^ cur[PAGE_BITS-2]);
        nxt = {cur[PAGE_BITS-2:0], fb};
    end
endmodule

// File: rtl/pc_load_decode.sv
module pc_load_decode
    import pc_unit_pkg::*;
#(
    parameter int UPPER_BITS = 6,
    parameter bit BANKED     = 1'b1
) (
    input  logic [OP_W-1:0]       opcode,
    input  logic                  status,
    input  logic                  bank_bit,
    output logic                  act,
    output logic [UPPER_BITS-1:0] prep
);
    always_comb begin
        act  = ((opcode & LOAD_MASK) == LOAD_MATCH) && status;
        prep = '0;
        prep[LOAD_FLD-1:0] = opcode[LOAD_FLD-1:0];
    end

    generate
        if (BANKED && UPPER_BITS > LOAD_FLD) begin : g_bank
            logic [UPPER_BITS-1:0] unused_prep;
            assign unused_prep = '0;
        end
    endgenerate
endmodule

// File: rtl/pc_upper_select.sv
module pc_upper_select #(
    parameter int UPPER_BITS = 6,
    parameter bit BANKED     = 1'b1
) (
    input  logic                  pend,
    input  logic [UPPER_BITS-1:0] cur_page,
    input  logic [UPPER_BITS-1:0] held,
    output logic [UPPER_BITS-1:0] nxt_page
);
    localparam int LIVE = BANKED ? UPPER_BITS : UPPER_BITS - 1;
    localparam logic [UPPER_BITS-1:0] HI_MASK = UPPER_BITS'((1 << LIVE) - 1);

    always_comb begin
        nxt_page = (pend ? held : cur_page) & HI_MASK;
    end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import pc_unit_pkg::*;
#(
    parameter int ADDR_BITS = 12,
    parameter int PAGE_BITS = 6,
    parameter bit BANKED    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch,
    input  logic [OP_W-1:0]      opcode,
    input  logic                 status,
    input  logic                 bank_bit,
    output logic [ADDR_BITS-1:0] rom_addr,
    output logic                 int_block
);
    localparam int UPPER_BITS = ADDR_BITS - PAGE_BITS;

    typedef struct packed {
        logic [UPPER_BITS-1:0] page;
        logic [PAGE_BITS-1:0]  low;
        logic [UPPER_BITS-1:0] held;
        logic                  pend;
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic [PAGE_BITS-1:0]  low_next_d;
    logic [UPPER_BITS-1:0] page_next_d;
    logic [UPPER_BITS-1:0] prep_raw_d;
    logic [UPPER_BITS-1:0] prep_d;
    logic                  act_d;

    pc_page_step #(.PAGE_BITS(PAGE_BITS)) u_step (
        .cur (st_q.low),
        .nxt (low_next_d)
    );

    pc_load_decode #(.UPPER_BITS(UPPER_BITS), .BANKED(BANKED)) u_dec (
        .opcode   (opcode),
        .status   (status),
        .bank_bit (bank_bit),
        .act      (act_d),
        .prep     (prep_raw_d)
    );

    // Bank bit sits just above the page-load field, inverted at capture time.
    generate
        if (BANKED && UPPER_BITS > LOAD_FLD) begin : g_bank_ins
            always_comb begin
                prep_d = prep_raw_d;
                prep_d[LOAD_FLD] = ~bank_bit;
            end
        end else begin : g_no_bank
            logic unused_bank;
            assign unused_bank = bank_bit;
            assign prep_d = prep_raw_d;
        end
    endgenerate

    pc_upper_select #(.UPPER_BITS(UPPER_BITS), .BANKED(BANKED)) u_sel (
        .pend     (st_q.pend),
        .cur_page (st_q.page),
        .held     (st_q.held),
        .nxt_page (page_next_d)
    );

    always_comb begin
        st_d = st_q;
        if (fetch) begin
            st_d.low  = low_next_d;
            st_d.page = page_next_d;
            st_d.pend = act_d;
            if (act_d) begin
                st_d.held = prep_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_addr  = {st_q.page, st_q.low};
    assign int_block = st_q.pend;
endmodule

// File: rtl/paged_pc_unit_chk.sv
module paged_pc_unit_chk
    import pc_unit_pkg::*;
#(
    parameter int ADDR_BITS = 12,
    parameter int PAGE_BITS = 6,
    parameter bit BANKED    = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch,
    input logic [OP_W-1:0]      opcode,
    input logic                 status,
    input logic [ADDR_BITS-1:0] rom_addr,
    input logic                 int_block
);
    logic is_load;
    assign is_load = (opcode[OP_W-1:LOAD_FLD] == 5'b11010) && status;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> ($stable(rom_addr) && $stable(int_block)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> rom_addr[PAGE_BITS-1:0] ==
            {$past(rom_addr[PAGE_BITS-2:0]),
             $past(rom_addr[PAGE_BITS-1]) ~^ $past(rom_addr[PAGE_BITS-2])});

    p_no_allones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[PAGE_BITS-1:0] != '1);

    p_page_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !int_block) |=>
            rom_addr[ADDR_BITS-1:PAGE_BITS] == $past(rom_addr[ADDR_BITS-1:PAGE_BITS]));

    p_block_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_block) |-> $past(fetch && is_load));

    p_block_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !is_load) |=> !int_block);

    generate
        if (!BANKED) begin : g_nb
            p_low_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !rom_addr[ADDR_BITS-1]);
        end
    endgenerate
endmodule

bind paged_pc_unit paged_pc_unit_chk #(
    .ADDR_BITS (ADDR_BITS),
    .PAGE_BITS (PAGE_BITS),
    .BANKED    (BANKED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch     (fetch),
    .opcode    (opcode),
    .status    (status),
    .rom_addr  (rom_addr),
    .int_block (int_block)
);

// File: tb/sim_paged_pc_unit.sv
`timescale 1ns/1ps
module sim_paged_pc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch = 1'b0;
    logic [9:0] opcode = '0;
    logic       status = 1'b0;
    logic       bank_bit = 1'b1;
    logic [11:0] addr0, addr1;
    logic        blk0, blk1;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [11:0] m0_pc, m1_pc;
    logic        m0_pend, m1_pend;
    logic [5:0]  m0_up, m1_up;

    always #2 clk = ~clk;

    paged_pc_unit #(.ADDR_BITS(12), .PAGE_BITS(6), .BANKED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .opcode(opcode),
        .status(status), .bank_bit(bank_bit), .rom_addr(addr0), .int_block(blk0));

    paged_pc_unit #(.ADDR_BITS(12), .PAGE_BITS(6), .BANKED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .opcode(opcode),
        .status(status), .bank_bit(bank_bit), .rom_addr(addr1), .int_block(blk1));

    function automatic logic [5:0] nxt6(input logic [5:0] x);
        return {x[4:0], ~(x[5] ^ x[4])};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic mdl(input bit banked, input logic [9:0] op, input logic st, input logic bk,
                       inout logic [11:0] pc, inout logic pend, inout logic [5:0] up);
        logic [5:0] lo, hi;
        logic act;
        lo  = nxt6(pc[5:0]);
        hi  = pend ? up : pc[11:6];
        act = (op[9:5] == 5'b11010) && st;
        if (act) up = {banked ? ~bk : 1'b0, op[4:0]};
        pend = act;
        pc = {hi, lo};
    endtask

    task automatic apply(input logic [9:0] op, input logic st, input logic bk,
                         input logic fe, input string tag);
        @(negedge clk);
        opcode = op; status = st; bank_bit = bk; fetch = fe;
        @(posedge clk);
        #1;
        if (fe) begin
            mdl(1'b1, op, st, bk, m0_pc, m0_pend, m0_up);
            mdl(1'b0, op, st, bk, m1_pc, m1_pend, m1_up);
        end
        chk({tag, " addr u0"}, 32'(addr0), 32'(m0_pc));
        chk({tag, " block u0"}, 32'(blk0), 32'(m0_pend));
        chk({tag, " addr u1"}, 32'(addr1), 32'(m1_pc));
        chk({tag, " block u1"}, 32'(blk1), 32'(m1_pend));
        chk("R9 upper half unused", 32'(addr1[11]), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m0_pc = '0; m1_pc = '0; m0_pend = 1'b0; m1_pend = 1'b0; m0_up = '0; m1_up = '0;
        #1;
        chk("R1 reset addr", 32'(addr0), 32'd0);
        chk("R1 reset block", 32'(blk0), 32'd0);
        chk("R1 reset addr nb", 32'(addr1), 32'd0);
    endtask

    initial begin
        logic [11:0] keep;
        logic [5:0]  start;
        do_reset();

        // R2: no fetch, acting page-load on the inputs, nothing moves
        for (int i = 0; i < 4; i++) begin
            apply(10'h35A, 1'b1, 1'b0, 1'b0, "R2 idle");
            chk("R2 idle addr", 32'(addr0), 32'd0);
            chk("R2 idle block", 32'(blk0), 32'd0);
        end

        // R3: full in-page period, page untouched (R4)
        start = addr0[5:0];
        for (int i = 1; i <= 63; i++) begin
            apply(10'h000, 1'b1, 1'b0, 1'b1, "R3 step");
            chk("R3 never all ones", 32'(addr0[5:0] == 6'h3F), 32'd0);
            chk("R4 page kept", 32'(addr0[11:6]), 32'd0);
            if (i < 63) chk("R3 no early repeat", 32'(addr0[5:0] == start), 32'd0);
        end
        chk("R3 period 63", 32'(addr0[5:0]), 32'(start));

        // R5..R8: every field, both bank values, both status values
        for (int f = 0; f < 32; f++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 2; s++) begin
                    keep = addr0;
                    apply({5'b11010, 5'(f)}, 1'(s), 1'(b), 1'b1, "R5 page-load");
                    chk(s ? "R5 block raised" : "R6 block stays low", 32'(blk0), 32'(s));
                    chk("R7 sequential after load", 32'(addr0[11:6]), 32'(keep[11:6]));
                    apply(10'h0A5, 1'b0, 1'(~b), 1'b1, "R7 next");
                    if (s) begin
                        chk("R7 page field", 32'(addr0[10:6]), 32'(f));
                        chk("R8 bank inverted", 32'(addr0[11]), 32'(~b & 1));
                        chk("R5 block cleared", 32'(blk0), 32'd0);
                    end else begin
                        chk("R6 page unchanged", 32'(addr0[11:6]), 32'(keep[11:6]));
                    end
                    keep = addr0;
                    apply(10'h3FF, 1'b1, 1'b0, 1'b1, "R4 ordinary");
                    chk("R4 page kept", 32'(addr0[11:6]), 32'(keep[11:6]));
                end
            end
        end

        // R10: back-to-back acting page-loads
        apply(10'h345, 1'b1, 1'b0, 1'b1, "R10 first load");
        apply(10'h34A, 1'b1, 1'b1, 1'b1, "R10 second load");
        chk("R10 first page applied", 32'(addr0[11:6]), 32'h25);
        chk("R10 still blocked", 32'(blk0), 32'd1);
        apply(10'h000, 1'b0, 1'b0, 1'b1, "R10 filler");
        chk("R10 second page applied", 32'(addr0[11:6]), 32'h0A);

        // All opcodes with varied status and bank against the model (R5, R6)
        for (int i = 0; i < 1024; i++) begin
            apply(10'(i), 1'(i[0] ^ i[3]), 1'(i[1]), 1'(i % 7 != 6), "R5 opcode sweep");
        end

        do_reset();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule